// File: doc/BRIEF.md
# Multi-Channel Pattern Shadow-Transfer Controller

This block decides the moment at which a freshly written output-pattern word moves from its shadow register into the active pattern register of a motor-control timer unit. Software writes the next pattern into the shadow register ahead of time. The block then commits it only when a chosen hardware event occurs, so the outputs switch in step with the motor's commutation.

The commit runs in two stages. A trigger selector watches event strobes from the primary timer (up/down counting), the secondary timer and a hall-pattern checker. The selected event raises a switching request. A synchronization selector then either commits that request on the next edge or holds it pending until a zero-match of one of the timers. A global multi-channel enable qualifies everything. The same enable, together with three per-direction enable bits, also gates the timers' own shadow-transfer strobes, which the block passes on registered.

Control word layout (`ctl_wdata`, loaded on `ctl_we`): bits [2:0] trigger select, bits [4:3] synchronization select, bit 5 primary up-count strobe enable, bit 6 primary down-count strobe enable, bit 7 secondary up-count strobe enable.

Top module: `mcp_xfer_ctrl`

## Requirements
- R1: After reset the control word, the shadow pattern, the active pattern, `req_pending`, `xfer_pulse` and all three strobe outputs are zero. The zero control word means no trigger and direct synchronization.
- R2: Each trigger-select code raises a request on its own event, with direction qualifiers where they apply. Code 1 uses `ev_hall_ok`. Code 2 uses `ev_sec_pm` while `sec_cnt_up`=1. Code 3 uses `ev_pri_om` while `pri_cnt_up`=0. Code 4 uses `ev_pri_cm1` in either direction. Code 5 uses `ev_pri_pm` while `pri_cnt_up`=1.
- R3: Trigger-select codes 0, 6 and 7 never raise a request, whatever events arrive.
- R4: With synchronization code 0, the active pattern takes the shadow value on the clock edge that samples the trigger. `xfer_pulse` is high for exactly the cycle after each commit, and the active pattern changes only in such cycles.
- R5: With synchronization code 1, a trigger sets `req_pending` and leaves the pattern unchanged. The next `ev_sec_zm` then commits the pattern and clears `req_pending`.
- R6: With synchronization code 2, a pending request commits only on `ev_pri_zm` while `pri_cnt_up`=1. A primary zero-match while counting down leaves the request pending.
- R7: Synchronization code 3 never commits a transfer, and a request pending under it stays pending.
- R8: If a trigger and the chosen sync event arrive in the same cycle while a request is pending, the pattern is committed once and `req_pending` ends set again by the new trigger.
- R9: While `mc_en`=0, `req_pending` is cleared on the next edge, no pattern transfer happens, and all strobe outputs stay low.
- R10: `st_pri_up_out` follows `st_pri_in` one cycle later only when `pri_cnt_up`=1, control bit 5 is 1 and `mc_en`=1. `st_pri_dn_out` does the same only when `pri_cnt_up`=0, control bit 6 is 1 and `mc_en`=1.
- R11: `st_sec_out` follows `st_sec_in` one cycle later only when `sec_cnt_up`=1, control bit 7 is 1 and `mc_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Global multi-channel enable |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word |
| shd_we | input | 1 | Shadow pattern write strobe |
| shd_wdata | input | PAT_W | Next pattern value |
| pri_cnt_up | input | 1 | Primary timer counts up (1) or down (0) |
| sec_cnt_up | input | 1 | Secondary timer counts up |
| ev_hall_ok | input | 1 | Correct hall pattern detected |
| ev_pri_pm | input | 1 | Primary timer period match |
| ev_pri_om | input | 1 | Primary timer one-match |
| ev_pri_cm1 | input | 1 | Primary timer channel-1 compare match |
| ev_pri_zm | input | 1 | Primary timer zero-match |
| ev_sec_pm | input | 1 | Secondary timer period match |
| ev_sec_zm | input | 1 | Secondary timer zero-match |
| st_pri_in | input | 1 | Primary timer shadow-transfer strobe |
| st_sec_in | input | 1 | Secondary timer shadow-transfer strobe |
| pat_out | output | PAT_W | Active multi-channel pattern |
| req_pending | output | 1 | Switching request waiting for sync |
| xfer_pulse | output | 1 | Pattern was committed on the last edge |
| st_pri_up_out | output | 1 | Gated primary up-count shadow strobe |
| st_pri_dn_out | output | 1 | Gated primary down-count shadow strobe |
| st_sec_out | output | 1 | Gated secondary shadow strobe |

## Verification
The assertions check four things on every cycle. The active pattern moves only together with `xfer_pulse`. A pending request drops whenever the global enable is low. Reserved trigger and sync codes never start or commit anything. Each gated strobe output is traced back to its input strobe and the enables of the previous cycle. Only the bench scenarios can show that each trigger code responds to its own event and direction, and that the right shadow value lands at the right edge. The same holds for the same-cycle commit and re-arm case, and for a request kept under the reserved sync code being released after a later switch of the sync field.

// File: rtl/mcp_pkg.sv
package mcp_pkg;

  typedef enum logic [2:0] {
    TRIG_NONE  = 3'd0,
    TRIG_HALL  = 3'd1,
    TRIG_SECPM = 3'd2,
    TRIG_PRIOM = 3'd3,
    TRIG_CM1   = 3'd4,
    TRIG_PRIPM = 3'd5,
    TRIG_RSV6  = 3'd6,
    TRIG_RSV7  = 3'd7
  } trig_e;

  typedef enum logic [1:0] {
    SYNC_DIRECT = 2'd0,
    SYNC_SECZM  = 2'd1,
    SYNC_PRIZM  = 2'd2,
    SYNC_RSV    = 2'd3
  } sync_e;

  // MSB first: bit7 sec up en, bit6 pri dn en, bit5 pri up en, [4:3] sync, [2:0] trig
  typedef struct packed {
    logic  sec_up_en;
    logic  pri_dn_en;
    logic  pri_up_en;
    sync_e sync;
    trig_e trig;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);

endpackage

// File: rtl/mcp_trig_decode.sv
module mcp_trig_decode
  import mcp_pkg::*;
(
  input  trig_e trig,
  input  sync_e sync,
  input  logic  pri_cnt_up,
  input  logic  sec_cnt_up,
  input  logic  ev_hall_ok,
  input  logic  ev_pri_pm,
  input  logic  ev_pri_om,
  input  logic  ev_pri_cm1,
  input  logic  ev_pri_zm,
  input  logic  ev_sec_pm,
  input  logic  ev_sec_zm,
  output logic  trig_hit,
  output logic  sync_hit
);

  always_comb begin
    case (trig)
      TRIG_HALL:  trig_hit = ev_hall_ok;
      TRIG_SECPM: trig_hit = ev_sec_pm & sec_cnt_up;
      TRIG_PRIOM: trig_hit = ev_pri_om & ~pri_cnt_up;
      TRIG_CM1:   trig_hit = ev_pri_cm1;
      TRIG_PRIPM: trig_hit = ev_pri_pm & pri_cnt_up;
      default:    trig_hit = 1'b0;
    endcase
  end

  always_comb begin
    case (sync)
      SYNC_SECZM: sync_hit = ev_sec_zm;
      SYNC_PRIZM: sync_hit = ev_pri_zm & pri_cnt_up;
      default:    sync_hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/mcp_sync_unit.sv
module mcp_sync_unit
  import mcp_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  mc_en,
  input  sync_e sync,
  input  logic  trig_hit,
  input  logic  sync_hit,
  output logic  commit,
  output logic  pend_q,
  output logic  xfer_q
);

  logic pend_d;

  always_comb begin
    commit = 1'b0;
    pend_d = 1'b0;
    if (mc_en) begin
      if (sync == SYNC_DIRECT) begin
        commit = trig_hit;
        pend_d = 1'b0;
      end else begin
        commit = pend_q & sync_hit;
        pend_d = trig_hit | (pend_q & ~commit);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      xfer_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      xfer_q <= commit;
    end
  end

endmodule

// File: rtl/mcp_strobe_gate.sv
module mcp_strobe_gate #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mc_en,
  input  logic [N-1:0] strobe,
  input  logic [N-1:0] dir_ok,
  input  logic [N-1:0] en,
  output logic [N-1:0] gated_q
);

  for (genvar i = 0; i < N; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) gated_q[i] <= 1'b0;
      else     gated_q[i] <= strobe[i] & dir_ok[i] & en[i] & mc_en;
    end
  end

endmodule

// File: rtl/mcp_xfer_ctrl.sv
module mcp_xfer_ctrl
  import mcp_pkg::*;
#(
  parameter int PAT_W = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mc_en,
  input  logic                    ctl_we,
  input  logic [CTL_W-1:0]        ctl_wdata,
  input  logic                    shd_we,
  input  logic [PAT_W-1:0]        shd_wdata,
  input  logic                    pri_cnt_up,
  input  logic                    sec_cnt_up,
  input  logic                    ev_hall_ok,
  input  logic                    ev_pri_pm,
  input  logic                    ev_pri_om,
  input  logic                    ev_pri_cm1,
  input  logic                    ev_pri_zm,
  input  logic                    ev_sec_pm,
  input  logic                    ev_sec_zm,
  input  logic                    st_pri_in,
  input  logic                    st_sec_in,
  output logic [PAT_W-1:0]        pat_out,
  output logic                    req_pending,
  output logic                    xfer_pulse,
  output logic                    st_pri_up_out,
  output logic                    st_pri_dn_out,
  output logic                    st_sec_out
);

  localparam int NSTB = 3;

  ctl_t             ctl_q;
  logic [PAT_W-1:0] shd_q;
  logic [PAT_W-1:0] act_q;
  logic             trig_hit;
  logic             sync_hit;
  logic             commit;
  logic [NSTB-1:0]  stb_in, stb_dir, stb_en, stb_q;

  always_ff @(posedge clk) begin
    if (rst)         ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_t'(ctl_wdata);
  end

  always_ff @(posedge clk) begin
    if (rst)         shd_q <= '0;
    else if (shd_we) shd_q <= shd_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)         act_q <= '0;
    else if (commit) act_q <= shd_q;
  end

  mcp_trig_decode u_dec (
    .trig       (ctl_q.trig),
    .sync       (ctl_q.sync),
    .pri_cnt_up (pri_cnt_up),
    .sec_cnt_up (sec_cnt_up),
    .ev_hall_ok (ev_hall_ok),
    .ev_pri_pm  (ev_pri_pm),
    .ev_pri_om  (ev_pri_om),
    .ev_pri_cm1 (ev_pri_cm1),
    .ev_pri_zm  (ev_pri_zm),
    .ev_sec_pm  (ev_sec_pm),
    .ev_sec_zm  (ev_sec_zm),
    .trig_hit   (trig_hit),
    .sync_hit   (sync_hit)
  );

  mcp_sync_unit u_sync (
    .clk      (clk),
    .rst      (rst),
    .mc_en    (mc_en),
    .sync     (ctl_q.sync),
    .trig_hit (trig_hit),
    .sync_hit (sync_hit),
    .commit   (commit),
    .pend_q   (req_pending),
    .xfer_q   (xfer_pulse)
  );

  assign stb_in  = {st_sec_in, st_pri_in, st_pri_in};
  assign stb_dir = {sec_cnt_up, ~pri_cnt_up, pri_cnt_up};
  assign stb_en  = {ctl_q.sec_up_en, ctl_q.pri_dn_en, ctl_q.pri_up_en};

  mcp_strobe_gate #(.N(NSTB)) u_gate (
    .clk     (clk),
    .rst     (rst),
    .mc_en   (mc_en),
    .strobe  (stb_in),
    .dir_ok  (stb_dir),
    .en      (stb_en),
    .gated_q (stb_q)
  );

  assign st_pri_up_out = stb_q[0];
  assign st_pri_dn_out = stb_q[1];
  assign st_sec_out    = stb_q[2];
  assign pat_out       = act_q;

endmodule

// File: rtl/mcp_xfer_ctrl_chk.sv
module mcp_xfer_ctrl_chk
  import mcp_pkg::*;
#(
  parameter int PAT_W = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             mc_en,
  input ctl_t             ctl_q,
  input logic             pri_cnt_up,
  input logic             sec_cnt_up,
  input logic             st_pri_in,
  input logic             st_sec_in,
  input logic [PAT_W-1:0] pat_out,
  input logic             req_pending,
  input logic             xfer_pulse,
  input logic             st_pri_up_out,
  input logic             st_pri_dn_out,
  input logic             st_sec_out
);

  assert_pat_moves_with_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    !xfer_pulse |-> $stable(pat_out));

  assert_disable_drops_pending_R9: assert property (@(posedge clk) disable iff (rst)
    !mc_en |=> (!req_pending && !xfer_pulse));

  assert_reserved_trig_idle_R3: assert property (@(posedge clk) disable iff (rst)
    ((ctl_q.trig == TRIG_NONE || ctl_q.trig == TRIG_RSV6 || ctl_q.trig == TRIG_RSV7)
     && !req_pending) |=> !req_pending);

  assert_reserved_sync_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (ctl_q.sync == SYNC_RSV && mc_en && req_pending) |=> (req_pending && !xfer_pulse));

  assert_pri_up_gate_R10: assert property (@(posedge clk) disable iff (rst)
    st_pri_up_out |-> $past(st_pri_in && pri_cnt_up && ctl_q.pri_up_en && mc_en));

  assert_pri_dn_gate_R10: assert property (@(posedge clk) disable iff (rst)
    st_pri_dn_out |-> $past(st_pri_in && !pri_cnt_up && ctl_q.pri_dn_en && mc_en));

  assert_sec_gate_R11: assert property (@(posedge clk) disable iff (rst)
    st_sec_out |-> $past(st_sec_in && sec_cnt_up && ctl_q.sec_up_en && mc_en));

endmodule

bind mcp_xfer_ctrl mcp_xfer_ctrl_chk #(.PAT_W(PAT_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .mc_en         (mc_en),
  .ctl_q         (ctl_q),
  .pri_cnt_up    (pri_cnt_up),
  .sec_cnt_up    (sec_cnt_up),
  .st_pri_in     (st_pri_in),
  .st_sec_in     (st_sec_in),
  .pat_out       (pat_out),
  .req_pending   (req_pending),
  .xfer_pulse    (xfer_pulse),
  .st_pri_up_out (st_pri_up_out),
  .st_pri_dn_out (st_pri_dn_out),
  .st_sec_out    (st_sec_out)
);

// File: tb/mcp_xfer_ctrl_bench.sv
`timescale 1ns/1ps
module mcp_xfer_ctrl_bench;

  localparam int PAT_W = 6;
  // event mask bits for fire()
  localparam int B_HALL = 0, B_PPM = 1, B_POM = 2, B_CM1 = 3, B_PZM = 4,
                 B_SPM = 5, B_SZM = 6, B_STP = 7, B_STS = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mc_en = 1'b0;
  logic ctl_we = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic shd_we = 1'b0;
  logic [PAT_W-1:0] shd_wdata = '0;
  logic pri_cnt_up = 1'b1, sec_cnt_up = 1'b1;
  logic ev_hall_ok = 0, ev_pri_pm = 0, ev_pri_om = 0, ev_pri_cm1 = 0;
  logic ev_pri_zm = 0, ev_sec_pm = 0, ev_sec_zm = 0, st_pri_in = 0, st_sec_in = 0;
  logic [PAT_W-1:0] pat_out;
  logic req_pending, xfer_pulse, st_pri_up_out, st_pri_dn_out, st_sec_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [PAT_W-1:0] exp_q[$];

  always #2 clk = ~clk;

  mcp_xfer_ctrl #(.PAT_W(PAT_W)) u_mcp_xfer_ctrl (
    .clk(clk), .rst(rst), .mc_en(mc_en), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .shd_we(shd_we), .shd_wdata(shd_wdata), .pri_cnt_up(pri_cnt_up),
    .sec_cnt_up(sec_cnt_up), .ev_hall_ok(ev_hall_ok), .ev_pri_pm(ev_pri_pm),
    .ev_pri_om(ev_pri_om), .ev_pri_cm1(ev_pri_cm1), .ev_pri_zm(ev_pri_zm),
    .ev_sec_pm(ev_sec_pm), .ev_sec_zm(ev_sec_zm), .st_pri_in(st_pri_in),
    .st_sec_in(st_sec_in), .pat_out(pat_out), .req_pending(req_pending),
    .xfer_pulse(xfer_pulse), .st_pri_up_out(st_pri_up_out),
    .st_pri_dn_out(st_pri_dn_out), .st_sec_out(st_sec_out)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input int trig, input int sync, input bit pu, input bit pd, input bit su);
    @(negedge clk);
    ctl_we = 1'b1;
    ctl_wdata = {su, pd, pu, 2'(sync), 3'(trig)};
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_shd(input int v);
    @(negedge clk);
    shd_we = 1'b1;
    shd_wdata = PAT_W'(v);
    @(negedge clk);
    shd_we = 1'b0;
  endtask

  task automatic drive(input int m);
    ev_hall_ok = m[B_HALL]; ev_pri_pm = m[B_PPM]; ev_pri_om = m[B_POM];
    ev_pri_cm1 = m[B_CM1];  ev_pri_zm = m[B_PZM]; ev_sec_pm = m[B_SPM];
    ev_sec_zm = m[B_SZM];   st_pri_in = m[B_STP]; st_sec_in = m[B_STS];
  endtask

  // one-cycle strobe; returns at the negedge after the sampling edge
  task automatic fire(input int m);
    @(negedge clk);
    drive(m);
    @(negedge clk);
    drive(0);
  endtask

  // scoreboard driver side
  task automatic expect_xfer(input int v);
    exp_q.push_back(PAT_W'(v));
  endtask

  // scoreboard monitor side (R4)
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!rst && xfer_pulse) begin
        if (exp_q.size() == 0) begin
          chk("R4 unexpected transfer", 1, 0);
        end else begin
          logic [PAT_W-1:0] e;
          e = exp_q.pop_front();
          chk("R4 committed pattern", int'(pat_out), int'(e));
        end
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 pat_out", int'(pat_out), 0);
    chk("R1 pending", int'(req_pending), 0);
    chk("R1 strobes", int'({xfer_pulse, st_pri_up_out, st_pri_dn_out, st_sec_out}), 0);
    fire(1 << B_HALL);            // zero control word: no trigger
    chk("R1 default ctl no request", int'(pat_out), 0);

    mc_en = 1'b1;
    // R4 direct
    wr_shd(6'h05);
    wr_ctl(1, 0, 0, 0, 0);
    expect_xfer(6'h05);
    fire(1 << B_HALL);
    chk("R4 direct load", int'(pat_out), 6'h05);
    chk("R4 no pending", int'(req_pending), 0);

    // R3 reserved triggers
    wr_shd(6'h3C);
    wr_ctl(6, 0, 0, 0, 0);
    fire(9'h07F);
    chk("R3 code6 ignored", int'(pat_out), 6'h05);
    wr_ctl(7, 1, 0, 0, 0);
    fire(9'h03F);
    chk("R3 code7 no pending", int'(req_pending), 0);
    wr_ctl(0, 0, 0, 0, 0);
    fire(9'h07F);
    chk("R3 code0 ignored", int'(pat_out), 6'h05);

    // R2 trigger codes with direction
    wr_ctl(2, 0, 0, 0, 0);
    sec_cnt_up = 1'b0;
    fire(1 << B_SPM);
    chk("R2 sec pm while down", int'(pat_out), 6'h05);
    sec_cnt_up = 1'b1;
    expect_xfer(6'h3C);
    fire(1 << B_SPM);
    chk("R2 sec pm up", int'(pat_out), 6'h3C);

    wr_shd(6'h12);
    wr_ctl(3, 0, 0, 0, 0);
    pri_cnt_up = 1'b1;
    fire(1 << B_POM);
    chk("R2 one-match while up", int'(pat_out), 6'h3C);
    pri_cnt_up = 1'b0;
    expect_xfer(6'h12);
    fire(1 << B_POM);
    chk("R2 one-match down", int'(pat_out), 6'h12);

    wr_shd(6'h21);
    wr_ctl(4, 0, 0, 0, 0);
    expect_xfer(6'h21);
    fire(1 << B_CM1);
    chk("R2 compare ch1", int'(pat_out), 6'h21);

    wr_shd(6'h0F);
    wr_ctl(5, 0, 0, 0, 0);
    fire(1 << B_PPM);             // still counting down
    chk("R2 pri pm while down", int'(pat_out), 6'h21);
    pri_cnt_up = 1'b1;
    expect_xfer(6'h0F);
    fire(1 << B_PPM);
    chk("R2 pri pm up", int'(pat_out), 6'h0F);

    // R5 sync on secondary zero
    wr_shd(6'h2A);
    wr_ctl(1, 1, 0, 0, 0);
    fire(1 << B_HALL);
    chk("R5 pending set", int'(req_pending), 1);
    chk("R5 pattern held", int'(pat_out), 6'h0F);
    fire(1 << B_PZM);
    chk("R5 other zero ignored", int'(req_pending), 1);
    expect_xfer(6'h2A);
    fire(1 << B_SZM);
    chk("R5 commit", int'(pat_out), 6'h2A);
    chk("R5 pending cleared", int'(req_pending), 0);

    // R6 sync on primary zero while up
    wr_shd(6'h33);
    wr_ctl(1, 2, 0, 0, 0);
    fire(1 << B_HALL);
    pri_cnt_up = 1'b0;
    fire(1 << B_PZM);
    chk("R6 zero while down held", int'(req_pending), 1);
    chk("R6 pattern held", int'(pat_out), 6'h2A);
    pri_cnt_up = 1'b1;
    expect_xfer(6'h33);
    fire(1 << B_PZM);
    chk("R6 commit", int'(pat_out), 6'h33);

    // R7 reserved sync
    wr_shd(6'h19);
    wr_ctl(1, 3, 0, 0, 0);
    fire(1 << B_HALL);
    fire((1 << B_SZM) | (1 << B_PZM));
    chk("R7 still pending", int'(req_pending), 1);
    chk("R7 no commit", int'(pat_out), 6'h33);
    wr_ctl(1, 1, 0, 0, 0);
    chk("R7 kept across ctl write", int'(req_pending), 1);
    expect_xfer(6'h19);
    fire(1 << B_SZM);
    chk("R7 released", int'(pat_out), 6'h19);

    // R8 same-cycle trigger and sync
    wr_shd(6'h11);
    fire(1 << B_HALL);
    expect_xfer(6'h11);
    fire((1 << B_HALL) | (1 << B_SZM));
    chk("R8 single commit", int'(pat_out), 6'h11);
    chk("R8 re-armed", int'(req_pending), 1);
    wr_shd(6'h22);
    expect_xfer(6'h22);
    fire(1 << B_SZM);
    chk("R8 second commit", int'(pat_out), 6'h22);
    chk("R8 cleared", int'(req_pending), 0);

    // R9 global enable
    wr_shd(6'h2D);
    fire(1 << B_HALL);
    @(negedge clk);
    mc_en = 1'b0;
    @(negedge clk);
    chk("R9 pending dropped", int'(req_pending), 0);
    fire((1 << B_HALL) | (1 << B_SZM));
    chk("R9 no commit", int'(pat_out), 6'h22);
    wr_ctl(1, 0, 1, 1, 1);
    fire((1 << B_HALL) | (1 << B_STP) | (1 << B_STS));
    chk("R9 direct blocked", int'(pat_out), 6'h22);
    chk("R9 strobes blocked", int'({st_pri_up_out, st_pri_dn_out, st_sec_out}), 0);

    // R10 / R11 strobe gating
    mc_en = 1'b1;
    wr_ctl(0, 0, 1, 0, 0);
    pri_cnt_up = 1'b1;
    fire(1 << B_STP);
    chk("R10 up strobe passes", int'({st_pri_up_out, st_pri_dn_out}), 2'b10);
    pri_cnt_up = 1'b0;
    fire(1 << B_STP);
    chk("R10 down strobe blocked", int'({st_pri_up_out, st_pri_dn_out}), 2'b00);
    wr_ctl(0, 0, 0, 1, 0);
    fire(1 << B_STP);
    chk("R10 down strobe passes", int'({st_pri_up_out, st_pri_dn_out}), 2'b01);
    fire(1 << B_STS);
    chk("R11 sec blocked by enable", int'(st_sec_out), 0);
    wr_ctl(0, 0, 0, 0, 1);
    sec_cnt_up = 1'b0;
    fire(1 << B_STS);
    chk("R11 sec blocked while down", int'(st_sec_out), 0);
    sec_cnt_up = 1'b1;
    fire(1 << B_STS);
    chk("R11 sec passes", int'(st_sec_out), 1);
    @(negedge clk);
    chk("R11 single cycle", int'(st_sec_out), 0);

    repeat (3) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule